// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two small unsigned operands one bit per clock, using two right-shifting operand registers, a single full-adder cell and a one-bit carry register. Both operands are captured in parallel by a load pulse. A start pulse then runs one pass of exactly `WIDTH` shift clocks. In each of these clocks the full adder combines the low bits of both operand registers with the stored carry. The sum bit enters the accumulating register at its top end, and the carry out is stored for the next bit.

When the pass ends, the accumulating register holds the sum, the carry register holds the final carry out, and a done flag rises. The second operand register is filled with zeros from its serial input while it shifts, so it is empty after the pass. A further start therefore adds zero to the result and leaves it unchanged.

Top module: `serial_adder_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state has `acc_o` = 0, `carry_o` = 0 and `done_o` = 0.
- R2: A cycle with `load_i` high captures `opa_i` into `acc_o` and the second operand internally, and after that edge `carry_o` = 0 and `done_o` = 0.
- R3: A start accepted at clock edge k causes shifting on edges k+1 through k+WIDTH. `done_o` is first high after edge k+WIDTH, and `done_o` is low after edges k through k+WIDTH-1.
- R4: After a pass that follows a load, {`carry_o`, `acc_o`} equals `opa_i` + `opb_i`, added as (WIDTH+1)-bit unsigned values.
- R5: The addition proceeds least significant bit first. After j shifts (1 ≤ j ≤ WIDTH), `acc_o[WIDTH-1 -: j]` holds bits j-1..0 of the sum, and `carry_o` holds the carry out of bit j-1.
- R6: A start that arrives while a pass is running is ignored. The pass still ends WIDTH shifts after its own start, with the same result.
- R7: When `load_i` and `start_i` are high in the same cycle, the load wins. Operands are captured, no pass begins, and `done_o` stays 0 until a later start.
- R8: A start clears `carry_o`. A pass run without a new load adds the emptied second operand (zero), so `acc_o` keeps its value and `carry_o` ends 0.
- R9: Outside a pass and without a load or start, `acc_o`, `carry_o` and `done_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Parallel capture of both operands; clears carry and done |
| start_i | input | 1 | Begins one pass of WIDTH shift clocks when no pass is running |
| opa_i | input | WIDTH | First operand, loaded into the accumulating register |
| opb_i | input | WIDTH | Second operand |
| acc_o | output | WIDTH | Accumulating register: first operand, then partial and final sum |
| carry_o | output | 1 | Carry register; final carry out after a pass |
| done_o | output | 1 | High once a pass has completed, until the next load or start |

## Verification
A wrong shift count in the pass counter shows on the first operation. `done_o` rises one edge early or late, and the result is then shifted by a bit position, so the sum is misaligned. A stuck or badly cleared carry register corrupts the upper sum bits, or `carry_o`, in the first pass whose bits generate or propagate a carry, at the edge after that bit. The same fault also shows in the follow-up pass, which must leave the sum intact. A missing zero fill of the second operand only shows at that follow-up pass, which would then change `acc_o`.

// File: rtl/serial_add_pkg.sv
// Shared types for the bit-serial adder.
// Assumes: nothing beyond standard SystemVerilog.
package serial_add_pkg;

    // Sequencer state: idle before a pass, running a pass, pass complete.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_t;

endpackage

// File: rtl/sa_shift_reg.sv
// Right-shifting register with parallel load and a serial input at its top bit.
// Assumes: load has priority over shift; reset is synchronous, active low.
module sa_shift_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             ser_i,
    output logic [WIDTH-1:0] q_o
);

    // Register update: reset, parallel capture, or one step right with ser_i entering at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (load_i) begin
            q_o <= par_i;
        end else if (shift_i) begin
            q_o <= {ser_i, q_o[WIDTH-1:1]};
        end
    end

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> (q_o[WIDTH-2:0] == $past(q_o[WIDTH-1:1]))); // R5

endmodule

// File: rtl/sa_full_adder.sv
// One-bit full adder cell: sum and carry out of three input bits.
// Assumes: purely combinational, no state.
module sa_full_adder (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);

    // Sum is the odd parity of the inputs; carry is their majority.
    always_comb begin
        s_o = a_i ^ b_i ^ c_i;
        c_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
    end

endmodule

// File: rtl/sa_sequencer.sv
// Pass sequencer: counts exactly WIDTH shift clocks per accepted start.
// Assumes: WIDTH is a power of two of at least 2; load aborts and resets the pass.
module sa_sequencer
    import serial_add_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic start_i,
    output logic go_o,
    output logic shift_o,
    output logic done_o
);

    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    seq_state_t    state_q;
    logic [CW-1:0] cnt_q;

    // A start is taken only when no load competes and no pass is running.
    always_comb begin
        go_o    = start_i && !load_i && (state_q != SEQ_RUN);
        shift_o = (state_q == SEQ_RUN);
        done_o  = (state_q == SEQ_DONE);
    end

    // State and shift counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else if (load_i) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else if (go_o) begin
            state_q <= SEQ_RUN;
            cnt_q   <= '0;
        end else if (state_q == SEQ_RUN) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
                state_q <= SEQ_DONE;
            end
        end
    end

    AST_GO_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |=> shift_o); // R3
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_o && !load_i && cnt_q == LAST) |=> done_o); // R3
    AST_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(shift_o)); // R3
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (!shift_o && !done_o)); // R7

endmodule

// File: rtl/serial_adder_top.sv
// Bit-serial adder: two right-shifting operand registers, one full adder, one carry register.
// The sum bit enters the accumulating register at its top; the second operand is zero filled.
// Assumes: one load before each fresh pair; start pulses while running are ignored.
module serial_adder_top #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             start_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    output logic [WIDTH-1:0] acc_o,
    output logic             carry_o,
    output logic             done_o
);

    logic             go;
    logic             shift;
    logic             sum_bit;
    logic             cout;
    logic [WIDTH-1:0] opb_q;

    sa_sequencer #(.WIDTH(WIDTH)) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .start_i (start_i),
        .go_o    (go),
        .shift_o (shift),
        .done_o  (done_o)
    );

    sa_shift_reg #(.WIDTH(WIDTH)) i_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .shift_i (shift),
        .par_i   (opa_i),
        .ser_i   (sum_bit),
        .q_o     (acc_o)
    );

    sa_shift_reg #(.WIDTH(WIDTH)) i_opb (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .shift_i (shift),
        .par_i   (opb_i),
        .ser_i   (1'b0),
        .q_o     (opb_q)
    );

    sa_full_adder i_fa (
        .a_i (acc_o[0]),
        .b_i (opb_q[0]),
        .c_i (carry_o),
        .s_o (sum_bit),
        .c_o (cout)
    );

    // Carry register: cleared by load or start, takes the adder carry on each shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_o <= 1'b0;
        end else if (load_i || go) begin
            carry_o <= 1'b0;
        end else if (shift) begin
            carry_o <= cout;
        end
    end

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (!carry_o && !done_o && acc_o == $past(opa_i))); // R2
    AST_SUM_ENTERS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load_i) |=> (acc_o[WIDTH-1] == ($past(acc_o[0]) ^ $past(opb_q[0]) ^ $past(carry_o)))); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift && !load_i && !start_i) |=> ($stable(acc_o) && $stable(carry_o) && $stable(done_o))); // R9
    AST_B_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load_i) |=> !opb_q[WIDTH-1]); // R8

endmodule

// File: tb/test_serial_adder_top.sv
module test_serial_adder_top;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] opa_i = '0;
    logic [W-1:0] opb_i = '0;
    logic [W-1:0] acc_o;
    logic         carry_o;
    logic         done_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [W:0] exp_q[$];
    logic       done_seen = 1'b0;

    always #10 clk = ~clk;

    serial_adder_top #(.WIDTH(W)) i_serial_adder_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .start_i (start_i),
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .acc_o   (acc_o),
        .carry_o (carry_o),
        .done_o  (done_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pops an expected result on every rising edge of done.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o && !done_seen) begin
                if (exp_q.size() == 0) begin
                    check("R4 unexpected done", 32'd1, 32'd0);
                end else begin
                    check("R4 sum", {27'd0, carry_o, acc_o}, {27'd0, exp_q.pop_front()});
                end
            end
            done_seen <= done_o;
        end else begin
            done_seen <= 1'b0;
        end
    end

    task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        opa_i = a; opb_i = b; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic do_start(input logic [W:0] expv);
        exp_q.push_back(expv);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done;
        while (!done_o) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++; errors++;
                $display("FAIL watchdog actual %0d expected <100000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        logic [W:0] s;
        logic [W-1:0] keep;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 acc", {28'd0, acc_o}, 32'd0);
        check("R1 carry", {31'd0, carry_o}, 32'd0);
        check("R1 done", {31'd0, done_o}, 32'd0);
        rst_n = 1'b1;

        // R5 and R3: cycle-by-cycle directed pass
        do_load(4'b1011, 4'b0110);
        s = 5'd17;
        exp_q.push_back(s);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R3 no done at start", {31'd0, done_o}, 32'd0);
        for (int j = 1; j <= W; j++) begin
            @(negedge clk);
            check("R5 partial sum", {28'd0, acc_o >> (W - j)}, {28'd0, s[W-1:0] & ((4'd1 << j) - 4'd1)});
            check("R5 carry", {31'd0, carry_o},
                  {31'd0, 1'(((5'(4'b1011 & ((4'd1 << j) - 4'd1))) + (5'(4'b0110 & ((4'd1 << j) - 4'd1)))) >> j)});
            check("R3 done timing", {31'd0, done_o}, {31'd0, (j == W)});
        end

        // R9 hold while idle after done
        repeat (3) @(negedge clk);
        check("R9 hold acc", {27'd0, carry_o, acc_o}, {27'd0, s});
        check("R9 hold done", {31'd0, done_o}, 32'd1);

        // R8 follow-up pass adds zero
        keep = acc_o;
        do_start({1'b0, keep});
        wait_done();
        check("R8 acc kept", {28'd0, acc_o}, {28'd0, keep});
        check("R8 carry zero", {31'd0, carry_o}, 32'd0);

        // R2 load after a carry-producing pass
        do_load(4'hF, 4'h1);
        do_start(5'h10);
        wait_done();
        do_load(4'h9, 4'h3);
        check("R2 acc", {28'd0, acc_o}, 32'h9);
        check("R2 carry", {31'd0, carry_o}, 32'd0);
        check("R2 done", {31'd0, done_o}, 32'd0);

        // R6 start while running ignored
        start_i = 1'b1; exp_q.push_back(5'd12);
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        check("R6 not done early", {31'd0, done_o}, 32'd0);
        @(negedge clk);
        check("R6 done on time", {31'd0, done_o}, 32'd1);
        check("R6 result", {27'd0, carry_o, acc_o}, 32'd12);

        // R7 load beats start
        @(negedge clk);
        opa_i = 4'h5; opb_i = 4'hA; load_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0; start_i = 1'b0;
        for (int k = 0; k < 6; k++) begin
            check("R7 no pass", {31'd0, done_o}, 32'd0);
            check("R7 acc held", {28'd0, acc_o}, 32'h5);
            @(negedge clk);
        end

        // R4 exhaustive sweep through the scoreboard
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                do_load(W'(a), W'(b));
                do_start(5'(a) + 5'(b));
                wait_done();
            end
        end
        repeat (2) @(negedge clk);
        check("R4 queue drained", exp_q.size(), 32'd0);
        finish_run();
    end

endmodule